// File: doc/BRIEF.md
# Standby entry request controller

This block turns register-bus accesses into standby entry requests for the clock controller. Software asks for one of two low-power modes, sleep or stop, by setting a request bit in a control register. A separate configuration register holds a synchronous-entry enable. With that enable cleared, the write alone starts standby. With it set, the write only arms the request, and a later read of the control register commits it.

A committed request becomes a one-cycle pulse on either the sleep or the stop output. The pulse comes in the cycle after the committing access. A wakeup input discards any armed request that has not been committed yet. Reading the control register returns the armed mode, so software can see what a read-back will commit.

Register map: the control register is at `CTRL_ADDR` (default 0). Its bit 0 requests sleep and bit 1 requests stop; when read, the same bits show the armed mode. The configuration register is at `CFG_ADDR` (default 1). Its bit 0 is the synchronous-entry enable. All other read bits, and reads of any other address, return 0. An access is a one-cycle strobe on `bus_wr` or `bus_rd` while `bus_sel` is high; a write takes priority over a read in the same cycle. Read data is combinational in the access cycle.

Top module: `stby_ctrl`

## Requirements
- R1: After reset the synchronous-entry enable (configuration bit 0) reads 0, and the control register reads 0. A configuration write stores bit 0, and a configuration read returns it.
- R2: With the enable at 0, a control write with bit 0 or bit 1 set produces a pulse on the matching output in the cycle after the write, and leaves nothing armed.
- R3: With the enable at 1, a control write with a request bit set produces no pulse and arms that mode. A later control read produces the armed mode's pulse in the cycle after the read and clears the armed state.
- R4: A control read with nothing armed produces no pulse and leaves the control register reading 0.
- R5: When a control write sets both bit 0 and bit 1, stop is the mode taken, whether it is pulsed or armed.
- R6: Each output pulse lasts one cycle per committing access, and sleep and stop are never high in the same cycle.
- R7: A wakeup input high during a cycle clears any armed request. A control access in that same cycle neither arms nor commits anything, so no pulse follows.
- R8: The enable may change while a request is armed, and the next control access follows the new setting. A read commits the armed mode in either setting. With the enable at 0, a control write with neither request bit set commits the armed mode. With the enable at 1, such a write leaves the armed mode unchanged.
- R9: A control read returns the armed mode in the access cycle: bit 0 for sleep, bit 1 for stop, and 0 when nothing is armed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Block selected for an access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the access cycle |
| wakeup_i | input | 1 | Wakeup, clears the armed request |
| sleep_req_o | output | 1 | One-cycle sleep entry request |
| stop_req_o | output | 1 | One-cycle stop entry request |

## Verification
Directed sequences cover these cases:
- A direct write in normal mode, checked against arm-then-read in synchronous mode, which shows whether the commit point moves with the enable.
- Reads with nothing armed, which separate a read-back commit from a read that merely observes.
- A write setting both request bits, which exposes the stop priority.
- A wakeup coinciding with an access, and an enable toggle while a request is armed, which probe the ordering between clearing, arming and committing.

Seeded random traffic then mixes writes, reads, configuration changes, unmapped accesses and wakeups. A bench model predicts every pulse and every read value.

// File: rtl/stby_pkg.sv
package stby_pkg;
  typedef enum logic [1:0] {
    MODE_NONE  = 2'd0,
    MODE_SLEEP = 2'd1,
    MODE_STOP  = 2'd2
  } stby_mode_e;

  localparam int NUM_MODES   = 2;
  localparam int SLEEP_BIT   = 0;
  localparam int STOP_BIT    = 1;
  localparam int SYNC_EN_BIT = 0;
endpackage

// File: rtl/stby_bus_dec.sv
module stby_bus_dec #(
  parameter int ADDR_W    = 4,
  parameter int CTRL_ADDR = 0,
  parameter int CFG_ADDR  = 1
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              ctrl_wr,
  output logic              ctrl_rd,
  output logic              cfg_wr,
  output logic              cfg_rd
);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] CFG_A  = ADDR_W'(CFG_ADDR);

  logic hit_ctrl, hit_cfg, wr_q, rd_q;

  always_comb begin
    hit_ctrl = bus_sel && (bus_addr == CTRL_A);
    hit_cfg  = bus_sel && (bus_addr == CFG_A);
    wr_q     = bus_wr;
    rd_q     = bus_rd && !bus_wr;
    ctrl_wr  = hit_ctrl && wr_q;
    ctrl_rd  = hit_ctrl && rd_q;
    cfg_wr   = hit_cfg && wr_q;
    cfg_rd   = hit_cfg && rd_q;
  end
endmodule

// File: rtl/stby_cfg_reg.sv
module stby_cfg_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_wr,
  input  logic wr_bit,
  output logic sync_en
);
  logic en_d, en_ce, en_q;

  always_comb begin
    en_ce = cfg_wr;
    en_d  = wr_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= 1'b0;
    else if (en_ce) en_q <= en_d;
  end

  assign sync_en = en_q;
endmodule

// File: rtl/stby_seq.sv
module stby_seq
  import stby_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr,
  input  logic       ctrl_rd,
  input  logic       req_sleep,
  input  logic       req_stop,
  input  logic       sync_en,
  input  logic       wakeup,
  output stby_mode_e armed,
  output logic       fire,
  output stby_mode_e fire_mode
);
  stby_mode_e armed_q, armed_d, req_mode;
  logic       armed_ce;

  always_comb begin
    if (req_stop)       req_mode = MODE_STOP;
    else if (req_sleep) req_mode = MODE_SLEEP;
    else                req_mode = MODE_NONE;
  end

  always_comb begin
    armed_d   = armed_q;
    fire      = 1'b0;
    fire_mode = MODE_NONE;
    if (wakeup) begin
      armed_d = MODE_NONE;
    end else if (ctrl_wr) begin
      if (req_mode != MODE_NONE) begin
        if (sync_en) begin
          armed_d = req_mode;
        end else begin
          fire      = 1'b1;
          fire_mode = req_mode;
          armed_d   = MODE_NONE;
        end
      end else if (!sync_en && armed_q != MODE_NONE) begin
        fire      = 1'b1;
        fire_mode = armed_q;
        armed_d   = MODE_NONE;
      end
    end else if (ctrl_rd && armed_q != MODE_NONE) begin
      fire      = 1'b1;
      fire_mode = armed_q;
      armed_d   = MODE_NONE;
    end
    armed_ce = (armed_d != armed_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed_q <= MODE_NONE;
    else if (armed_ce) armed_q <= armed_d;
  end

  assign armed = armed_q;

  AST_WAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wakeup |=> armed_q == MODE_NONE); // R7
  AST_ARMED_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q != 2'd3); // R9
  AST_NORMAL_WR_NO_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && !sync_en |=> armed_q == MODE_NONE); // R2
endmodule

// File: rtl/stby_pulse.sv
module stby_pulse
  import stby_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fire,
  input  stby_mode_e           fire_mode,
  output logic [NUM_MODES-1:0] pulse
);
  logic [NUM_MODES-1:0] pulse_d, pulse_q;

  for (genvar g = 0; g < NUM_MODES; g++) begin : g_mode
    always_comb pulse_d[g] = fire && (fire_mode == stby_mode_e'(g + 1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse_q[g] <= 1'b0;
      else        pulse_q[g] <= pulse_d[g];
    end
  end

  assign pulse = pulse_q;

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pulse_q)); // R6
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (|pulse_q) && !fire |=> pulse_q == '0); // R6
endmodule

// File: rtl/stby_ctrl.sv
module stby_ctrl
  import stby_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int CTRL_ADDR = 0,
  parameter int CFG_ADDR  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              wakeup_i,
  output logic              sleep_req_o,
  output logic              stop_req_o
);
  logic                 ctrl_wr, ctrl_rd, cfg_wr, cfg_rd;
  logic                 sync_en, fire;
  stby_mode_e           armed, fire_mode;
  logic [NUM_MODES-1:0] pulse;

  stby_bus_dec #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .CFG_ADDR(CFG_ADDR)
  ) u_dec (
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .ctrl_wr(ctrl_wr), .ctrl_rd(ctrl_rd), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd)
  );

  stby_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr),
    .wr_bit(bus_wdata[SYNC_EN_BIT]), .sync_en(sync_en)
  );

  stby_seq u_seq (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_rd(ctrl_rd),
    .req_sleep(bus_wdata[SLEEP_BIT]), .req_stop(bus_wdata[STOP_BIT]),
    .sync_en(sync_en), .wakeup(wakeup_i),
    .armed(armed), .fire(fire), .fire_mode(fire_mode)
  );

  stby_pulse u_pulse (
    .clk(clk), .rst_n(rst_n), .fire(fire), .fire_mode(fire_mode), .pulse(pulse)
  );

  always_comb begin
    bus_rdata = '0;
    if (ctrl_rd) begin
      bus_rdata[SLEEP_BIT] = (armed == MODE_SLEEP);
      bus_rdata[STOP_BIT]  = (armed == MODE_STOP);
    end else if (cfg_rd) begin
      bus_rdata[SYNC_EN_BIT] = sync_en;
    end
  end

  assign sleep_req_o = pulse[0];
  assign stop_req_o  = pulse[1];

  AST_WAKE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wakeup_i |=> !sleep_req_o && !stop_req_o); // R7
  AST_SYNC_WR_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && sync_en |=> !sleep_req_o && !stop_req_o); // R3
  AST_IDLE_RD_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd && bus_rdata == '0 |=> !sleep_req_o && !stop_req_o); // R4
  AST_STOP_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && !sync_en && !wakeup_i && bus_wdata[STOP_BIT] |=> stop_req_o); // R5
  AST_RD_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd && !wakeup_i && bus_rdata[STOP_BIT] |=> stop_req_o); // R3
endmodule

// File: tb/stby_ctrl_bench.sv
module stby_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_sel, bus_wr, bus_rd, wakeup_i;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       sleep_req_o, stop_req_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  bit         m_en;
  int         m_arm;
  logic [1:0] exp_pulse;
  string      prev_tag;

  always #2 clk = ~clk;

  stby_ctrl u_stby_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .wakeup_i(wakeup_i),
    .sleep_req_o(sleep_req_o), .stop_req_o(stop_req_o)
  );

  function automatic logic [1:0] pulse_of(input int mode);
    return (mode == 1) ? 2'b01 : (mode == 2) ? 2'b10 : 2'b00;
  endfunction

  function automatic logic [7:0] exp_rd(input logic [3:0] a);
    if (a == 4'd0) return {6'd0, pulse_of(m_arm)};
    if (a == 4'd1) return {7'd0, m_en};
    return 8'd0;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic op(input bit wr, input bit rd, input logic [3:0] a,
                    input logic [7:0] d, input bit wk, input string tag);
    int p;
    int r;
    @(negedge clk);
    check({prev_tag, " pulse"}, {6'd0, stop_req_o, sleep_req_o}, {6'd0, exp_pulse});
    bus_sel = wr | rd; bus_wr = wr; bus_rd = rd; bus_addr = a;
    bus_wdata = d; wakeup_i = wk;
    #1;
    if (rd) check({tag, " rdata"}, bus_rdata, exp_rd(a));
    p = 0;
    if (wr && a == 4'd1) m_en = d[0];
    if (wk) m_arm = 0;
    else if (wr && a == 4'd0) begin
      r = d[1] ? 2 : d[0] ? 1 : 0;
      if (r != 0) begin
        if (m_en) m_arm = r;
        else begin p = r; m_arm = 0; end
      end else if (!m_en && m_arm != 0) begin
        p = m_arm; m_arm = 0;
      end
    end else if (rd && a == 4'd0 && m_arm != 0) begin
      p = m_arm; m_arm = 0;
    end
    exp_pulse = pulse_of(p);
    prev_tag  = tag;
  endtask

  task automatic idle(input string tag);
    op(1'b0, 1'b0, 4'd0, 8'd0, 1'b0, tag);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_sel = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0;
    bus_wdata = 0; wakeup_i = 0;
    m_en = 0; m_arm = 0; exp_pulse = 2'b00; prev_tag = "reset";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    void'($urandom(32'd5151));

    op(0, 1, 4'd1, 8'h00, 0, "R1 reset enable");
    op(0, 1, 4'd0, 8'h00, 0, "R1 R4 reset ctrl");
    op(1, 0, 4'd0, 8'h01, 0, "R2 sleep write");
    op(1, 0, 4'd0, 8'h02, 0, "R2 stop write");
    op(1, 0, 4'd0, 8'h03, 0, "R5 both normal");
    idle("R6 after pulse");
    op(1, 0, 4'd1, 8'h01, 0, "R1 enable set");
    op(0, 1, 4'd1, 8'h00, 0, "R1 enable read");
    op(1, 0, 4'd0, 8'h01, 0, "R3 arm sleep");
    idle("R3 no pulse");
    op(0, 1, 4'd0, 8'h00, 0, "R3 R9 commit read");
    op(0, 1, 4'd0, 8'h00, 0, "R4 read idle");
    op(1, 0, 4'd0, 8'h03, 0, "R5 both arm");
    op(0, 1, 4'd0, 8'h00, 0, "R5 R9 stop commit");
    op(1, 0, 4'd0, 8'h02, 0, "R7 arm stop");
    op(0, 0, 4'd0, 8'h00, 1, "R7 wakeup");
    op(0, 1, 4'd0, 8'h00, 0, "R7 read cleared");
    op(1, 0, 4'd0, 8'h01, 0, "R7 arm again");
    op(0, 1, 4'd0, 8'h00, 1, "R7 read with wakeup");
    op(0, 1, 4'd0, 8'h00, 0, "R7 read after");
    op(1, 0, 4'd0, 8'h02, 0, "R8 arm stop");
    op(1, 0, 4'd0, 8'h00, 0, "R8 empty write sync");
    op(1, 0, 4'd1, 8'h00, 0, "R8 enable off");
    op(0, 1, 4'd0, 8'h00, 0, "R8 R9 armed visible");
    op(1, 0, 4'd1, 8'h01, 0, "R8 enable on");
    op(1, 0, 4'd0, 8'h01, 0, "R8 arm sleep");
    op(1, 0, 4'd1, 8'h00, 0, "R8 enable off");
    op(1, 0, 4'd0, 8'h00, 0, "R8 empty write commits");
    idle("R6 settle");

    for (int i = 0; i < 3000; i++) begin
      int k;
      logic [7:0] d;
      bit wk;
      k  = $urandom_range(0, 9);
      d  = 8'($urandom);
      wk = ($urandom_range(0, 11) == 0);
      case (k)
        0, 1, 2: op(1, 0, 4'd0, d, wk, "R2 R3 R5 rnd ctrl wr");
        3, 4, 5: op(0, 1, 4'd0, d, wk, "R3 R4 R9 rnd ctrl rd");
        6:       op(1, 0, 4'd1, d, wk, "R1 R8 rnd cfg wr");
        7:       op(0, 1, 4'd1, d, wk, "R1 rnd cfg rd");
        8:       op($urandom_range(0, 1) == 1, 1'b0, 4'($urandom_range(2, 15)), d, wk, "R6 rnd unmapped");
        default: op(0, 0, 4'd0, d, wk, "R6 R7 rnd idle");
      endcase
    end
    idle("R6 final");
    idle("R6 final2");

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule